// File: doc/BRIEF.md
# Multi-Channel Pin Transition Detector

This block watches a small group of asynchronous digital input pins and turns selected transitions on each of them into single-cycle event pulses. Every pin passes through a multi-flop synchroniser; the synchronised level is compared, at each assertion of a sampling strobe, with the level seen at the previous strobe. A rising or falling difference then becomes an event if the channel is enabled and its trigger field asks for that kind of transition. The result is one event vector with one bit per channel. It is meant to feed a timestamp capture and queueing stage that sits downstream.

Each channel has a two-bit trigger field. The field selects one of four trigger kinds: rising edges, falling edges, both edges, or every eighth rising edge. The last kind uses a private divide-by-eight counter per channel. The synchronised pin levels are also brought out continuously, so software-facing logic can read pin state even when no channel is enabled.

Top module: `pin_event_detect`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `events_o` and `levels_o` are all zero.
- R2: `levels_o[n]` follows `pins_i[n]` two clock cycles after a change. This holds whether channel n is enabled or not and whether the strobe is high or low.
- R3: A trigger field value of 2'b01 (channel n uses `mode_i[2n+1:2n]`) makes every rising transition an event and ignores falling ones.
- R4: A trigger field value of 2'b10 makes every falling transition an event and ignores rising ones.
- R5: A trigger field value of 2'b11 makes both rising and falling transitions events.
- R6: A trigger field value of 2'b00 makes an event on the 8th, 16th, ... rising transition after the counter was last cleared. Falling transitions neither count nor produce events.
- R7: Any change of a channel's trigger field clears that channel's eighth-edge counter.
- R8: Channel n is enabled by `ctrl_i[2n]` (bits 0, 2, 4, 6). While that bit is low, channel n produces no event, and the odd control bits have no effect.
- R9: Disabling a channel clears its eighth-edge counter.
- R10: Transitions are judged only at cycles where `strobe_i` is high, against the level at the previous strobe. A pulse that starts and ends between strobes is lost. `events_o` is zero in any cycle not preceded by a strobe cycle.
- R11: A pin change produces its event bit in the third cycle after the change. Channels that change in the same cycle report together in one vector, and each event bit lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | NUM_CH | Asynchronous input pins |
| mode_i | input | 2*NUM_CH | Per-channel two-bit trigger fields |
| ctrl_i | input | 2*NUM_CH | Control byte; even bits enable the channels |
| strobe_i | input | 1 | Sampling strobe, one state time |
| events_o | output | NUM_CH | Event vector, one pulse per detected trigger |
| levels_o | output | NUM_CH | Synchronised pin levels |

## Verification
The hardest state to reach is a half-filled eighth-edge counter that has to be cleared by something other than counting. A counter left at five after a mode change or a disable, and then missed by the clear, only becomes visible several edges later, as an event that arrives too early. The stimulus drives a partial run of rising edges, toggles the trigger field or the enable bit, restores it, and then applies exactly seven more edges, which must produce nothing, followed by an eighth, which must produce exactly one event. Lost pulses between strobes are reached by holding the strobe low while a pin makes a complete round trip.

// File: rtl/ped_pkg.sv
package ped_pkg;
   typedef enum logic [1:0] {
      TRIG_EIGHTH = 2'b00,
      TRIG_RISE   = 2'b01,
      TRIG_FALL   = 2'b10,
      TRIG_ANY    = 2'b11
   } trig_e;

   function automatic logic is_pow2(input int v);
      return (v > 1) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/ped_sync.sv
module ped_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ped_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[0] <= '0;
            else        stage_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ped_chan.sv
module ped_chan
   import ped_pkg::*;
#(
   parameter int PRESCALE = 8
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  level_i,
   input  logic  strobe_i,
   input  logic  enable_i,
   input  trig_e trig_i,
   output logic  hit_o
);
   localparam int CNT_W = $clog2(PRESCALE);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRESCALE - 1);

   logic             sampled_q;
   trig_e            trig_q;
   logic [CNT_W-1:0] div_q;
   logic             rise, fall, trig_chg, div_wrap;

   // level seen at the last strobe
   always_ff @(posedge clk) begin
      if (!rst_n)        sampled_q <= 1'b0;
      else if (strobe_i) sampled_q <= level_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) trig_q <= TRIG_EIGHTH;
      else        trig_q <= trig_i;
   end

   assign rise     = strobe_i &  level_i & ~sampled_q;
   assign fall     = strobe_i & ~level_i &  sampled_q;
   assign trig_chg = (trig_i != trig_q);
   assign div_wrap = (div_q == CNT_LAST);

   // divide-by-PRESCALE rising edge counter
   always_ff @(posedge clk) begin
      if (!rst_n)                      div_q <= '0;
      else if (!enable_i || trig_chg)  div_q <= '0;
      else if (trig_i == TRIG_EIGHTH && rise)
         div_q <= div_wrap ? '0 : div_q + 1'b1;
   end

   always_comb begin
      hit_o = 1'b0;
      if (enable_i) begin
         unique case (trig_i)
            TRIG_EIGHTH: hit_o = rise & div_wrap & ~trig_chg;
            TRIG_RISE:   hit_o = rise;
            TRIG_FALL:   hit_o = fall;
            TRIG_ANY:    hit_o = rise | fall;
            default:     hit_o = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/pin_event_detect.sv
module pin_event_detect
   import ped_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int PRESCALE    = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_CH-1:0]     pins_i,
   input  logic [2*NUM_CH-1:0]   mode_i,
   input  logic [2*NUM_CH-1:0]   ctrl_i,
   input  logic                  strobe_i,
   output logic [NUM_CH-1:0]     events_o,
   output logic [NUM_CH-1:0]     levels_o
);
   localparam int FIELD_W = 2;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("pin_event_detect: NUM_CH must be positive");
   end
   if (!is_pow2(PRESCALE)) begin : g_bad_pre
      $error("pin_event_detect: PRESCALE must be a power of two above 1");
   end

   logic [NUM_CH-1:0] level_sync;
   logic [NUM_CH-1:0] hit;

   ped_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pins_i),
      .sync_o  (level_sync)
   );

   for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
      ped_chan #(.PRESCALE(PRESCALE)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .level_i  (level_sync[n]),
         .strobe_i (strobe_i),
         .enable_i (ctrl_i[FIELD_W*n]),
         .trig_i   (trig_e'(mode_i[FIELD_W*n +: FIELD_W])),
         .hit_o    (hit[n])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) events_o <= '0;
      else        events_o <= hit;
   end

   assign levels_o = level_sync;
endmodule

// File: rtl/pin_event_detect_chk.sv
module pin_event_detect_chk #(
   parameter int NUM_CH = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_CH-1:0]   pins_i,
   input logic [2*NUM_CH-1:0] mode_i,
   input logic [2*NUM_CH-1:0] ctrl_i,
   input logic                strobe_i,
   input logic [NUM_CH-1:0]   events_o,
   input logic [NUM_CH-1:0]   levels_o
);
   // R10
   no_event_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_i |=> (events_o == '0));

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      // R8
      disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !ctrl_i[2*n] |=> !events_o[n]);
      // R3
      rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (events_o[n] && $past(mode_i[2*n +: 2]) == 2'b01) |-> $past(levels_o[n]));
      // R4
      fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (events_o[n] && $past(mode_i[2*n +: 2]) == 2'b10) |-> !$past(levels_o[n]));
   end
endmodule

bind pin_event_detect pin_event_detect_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/pin_event_detect_bench.sv
module pin_event_detect_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] pins_i = '0;
   logic [7:0] mode_i = 8'h55;
   logic [7:0] ctrl_i = 8'h55;
   logic       strobe_i = 1'b1;
   logic [3:0] events_o, levels_o;

   int n_chk = 0;
   int n_bad = 0;
   int ev_cnt [4];

   always #2 clk = ~clk;

   pin_event_detect u_pin_event_detect (
      .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .mode_i(mode_i),
      .ctrl_i(ctrl_i), .strobe_i(strobe_i), .events_o(events_o), .levels_o(levels_o)
   );

   always @(negedge clk)
      if (rst_n) for (int i = 0; i < 4; i++) ev_cnt[i] += int'(events_o[i]);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_counts();
      for (int i = 0; i < 4; i++) ev_cnt[i] = 0;
   endtask

   task automatic drive(input logic [3:0] v);
      @(negedge clk); pins_i = v;
      repeat (5) @(negedge clk);
   endtask

   task automatic pulses(input logic [3:0] m, input int k);
      for (int i = 0; i < k; i++) begin
         drive(pins_i | m);
         drive(pins_i & ~m);
      end
   endtask

   task automatic quiet_start(input logic [7:0] md, input logic [7:0] en);
      @(negedge clk); pins_i = '0; strobe_i = 1'b1; mode_i = md; ctrl_i = en;
      repeat (6) @(negedge clk);
      clear_counts();
   endtask

   task automatic t_reset();
      rst_n = 1'b0; pins_i = 4'hF;
      repeat (3) @(negedge clk);
      check(events_o == 0 && levels_o == 0, "R1 in reset", {events_o, levels_o}, 0);
      @(negedge clk); rst_n = 1'b1; pins_i = '0;
      @(negedge clk);
      check(events_o == 0 && levels_o == 0, "R1 after reset", {events_o, levels_o}, 0);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_levels();
      quiet_start(8'h55, 8'hAA);
      @(negedge clk); pins_i = 4'hA; strobe_i = 1'b0;
      @(negedge clk);
      check(levels_o == 4'h0, "R2 one cycle", levels_o, 0);
      @(negedge clk);
      check(levels_o == 4'hA, "R2 two cycles", levels_o, 4'hA);
      repeat (4) @(negedge clk);
      strobe_i = 1'b1;
      drive(4'h5);
      check(levels_o == 4'h5, "R2 disabled", levels_o, 4'h5);
      check(ev_cnt[0] + ev_cnt[1] + ev_cnt[2] + ev_cnt[3] == 0, "R8 odd bits no enable",
            ev_cnt[0] + ev_cnt[1] + ev_cnt[2] + ev_cnt[3], 0);
   endtask

   task automatic t_rise_fall_any();
      quiet_start(8'b11_10_01_01, 8'h55);
      pulses(4'hF, 3);
      check(ev_cnt[0] == 3, "R3 ch0 rises", ev_cnt[0], 3);
      check(ev_cnt[1] == 3, "R3 ch1 rises", ev_cnt[1], 3);
      check(ev_cnt[2] == 3, "R4 ch2 falls", ev_cnt[2], 3);
      check(ev_cnt[3] == 6, "R5 ch3 both", ev_cnt[3], 6);
      clear_counts();
      drive(4'hF);
      check(ev_cnt[2] == 0 && ev_cnt[0] == 1, "R4 rise ignored", ev_cnt[2], 0);
      clear_counts();
      drive(4'h0);
      check(ev_cnt[0] == 0 && ev_cnt[2] == 1, "R3 fall ignored", ev_cnt[0], 0);
   endtask

   task automatic t_eighth();
      quiet_start(8'h00, 8'h55);
      pulses(4'hF, 7);
      check(ev_cnt[1] == 0, "R6 seven rises", ev_cnt[1], 0);
      drive(4'hF);
      check(ev_cnt[1] == 1 && ev_cnt[3] == 1, "R6 eighth rise", ev_cnt[1], 1);
      drive(4'h0);
      check(ev_cnt[0] == 1, "R6 fall not counted", ev_cnt[0], 1);
      pulses(4'hF, 8);
      check(ev_cnt[2] == 2, "R6 sixteenth", ev_cnt[2], 2);
   endtask

   task automatic t_mode_restart();
      quiet_start(8'h00, 8'h55);
      pulses(4'h1, 5);
      @(negedge clk); mode_i = 8'h01;
      repeat (3) @(negedge clk); mode_i = 8'h00;
      repeat (3) @(negedge clk);
      clear_counts();
      pulses(4'h1, 7);
      check(ev_cnt[0] == 0, "R7 cleared on mode change", ev_cnt[0], 0);
      pulses(4'h1, 1);
      check(ev_cnt[0] == 1, "R7 eighth after change", ev_cnt[0], 1);
   endtask

   task automatic t_disable();
      quiet_start(8'h00, 8'h55);
      pulses(4'h2, 5);
      @(negedge clk); ctrl_i = 8'h51;
      pulses(4'h2, 9);
      check(ev_cnt[1] == 0, "R8 disabled silent", ev_cnt[1], 0);
      @(negedge clk); ctrl_i = 8'h55;
      repeat (3) @(negedge clk);
      pulses(4'h2, 7);
      check(ev_cnt[1] == 0, "R9 cleared on disable", ev_cnt[1], 0);
      pulses(4'h2, 1);
      check(ev_cnt[1] == 1, "R9 eighth after enable", ev_cnt[1], 1);
   endtask

   task automatic t_strobe();
      quiet_start(8'h55, 8'h55);
      @(negedge clk); strobe_i = 1'b0;
      pulses(4'h8, 2);
      check(ev_cnt[3] == 0, "R10 pulse between strobes", ev_cnt[3], 0);
      drive(4'h8);
      check(ev_cnt[3] == 0, "R10 no strobe", ev_cnt[3], 0);
      @(negedge clk); strobe_i = 1'b1;
      @(negedge clk); strobe_i = 1'b0;
      check(events_o == 4'h8, "R10 event at strobe", events_o, 4'h8);
      @(negedge clk);
      check(events_o == 4'h0, "R10 one cycle", events_o, 0);
      strobe_i = 1'b1;
      repeat (3) @(negedge clk);
      check(ev_cnt[3] == 1, "R10 single event", ev_cnt[3], 1);
   endtask

   task automatic t_latency();
      quiet_start(8'h55, 8'h55);
      @(negedge clk); pins_i = 4'hF;
      @(negedge clk);
      check(events_o == 0, "R11 cycle1", events_o, 0);
      @(negedge clk);
      check(events_o == 0, "R11 cycle2", events_o, 0);
      @(negedge clk);
      check(events_o == 4'hF, "R11 joint vector", events_o, 4'hF);
      @(negedge clk);
      check(events_o == 0, "R11 one-cycle pulse", events_o, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_levels();
      t_rise_fall_any();
      t_eighth();
      t_mode_restart();
      t_disable();
      t_strobe();
      t_latency();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule